// File: doc/BRIEF.md
# Reset Release Delay Sequencer

This block decides when a chip leaves reset after a reset event. It takes reset causes as single-cycle pulses: power-on, brown-out, and a set of short-path causes (external pin, watchdog, software, illegal opcode, uninitialized working register, trap conflict). It also takes a two-bit power-up delay code and a two-bit clock source code. From these it releases the system reset, enables the core clock, and signals when clock-failure monitoring may begin. The oscillator, the PLL and the monitor's own detection logic sit outside the block. Their timing enters only through a one-cycle reference tick (`ref_tick`) and a one-cycle oscillator edge strobe (`osc_edge`), both synchronous to `clk`.

The reset delay, the oscillator start-up count and the PLL lock delay all begin together when the cause arrives. The reset delay is counted in its own timer. A second machine carries the clock-readiness chain (start-up count, then lock), so the clock delays run alongside the reset delay. The main machine has four states:
- S_IDLE: held after block reset until the first cause.
- S_HOLD: system reset held while the reset delay counts.
- S_WAITCLK: system reset released, clock not yet ready.
- S_RUN: clock enabled.

The main machine has these transitions:
- Any cause moves it from every state to S_HOLD.
- In S_HOLD, an expired delay leads to S_RUN if the clock is ready, otherwise to S_WAITCLK.
- S_WAITCLK moves to S_RUN once the clock is ready.

The clock machine has three states:
- C_OST: counting oscillator edges.
- C_LOCK: counting PLL lock ticks.
- C_READY: clock ready.

A power-on or brown-out cause enters C_OST if a crystal is selected, otherwise C_LOCK if the PLL is selected, otherwise C_READY. A short-path cause enters C_READY directly. C_OST moves to C_LOCK if the PLL is selected, otherwise to C_READY. C_LOCK moves to C_READY.

Top module: `reset_release_seq`

## Requirements
- R1: After `arst_n` is deasserted, `sys_reset`=1, `clk_en`=0, `mon_on`=0 and `last_cause`=0. These hold, whatever the ticks and oscillator edges, until a cause pulse arrives.
- R2: After a power-on pulse, `sys_reset` stays 1 until POR_TICKS plus the power-up delay of reference ticks have been counted. Ticks are counted from the cycle after the pulse. `sys_reset` falls in the cycle after the last of those ticks.
- R3: A brown-out pulse holds `sys_reset` for the power-up delay only. The `pwrt_sel` codes 0, 1, 2 and 3 give 0, 4, 16 and 64 times TICKS_PER_MS ticks.
- R4: A short-path pulse on any `fast_evt` bit, with no power-on or brown-out pulse, gives `sys_reset`=1 for exactly one cycle. In the next cycle `clk_en`=1, and for a non-plain source `mon_on`=1 as well.
- R5: `clk_src` bit 0 selects a crystal. With a crystal, the clock is not ready until OST_EDGES `osc_edge` strobes have been counted after the cause.
- R6: `clk_src` bit 1 selects the PLL. With the PLL, readiness also needs LOCK_TICKS ticks. With a crystal, those ticks are counted only after the start-up count has finished.
- R7: The clock delays run alongside the reset delay. `clk_en`=1 only when `sys_reset`=0 and the clock is ready, and it rises as soon as both hold.
- R8: For `clk_src` 1, 2 or 3, `mon_on` rises MON_TICKS ticks after `sys_reset` falls following a power-on or brown-out cause. For `clk_src`=0, `mon_on` stays 0.
- R9: Any cause pulse restarts the sequence from the start in the next cycle. `sys_reset` is 1 and `clk_en` and `mon_on` are 0, whatever was under way.
- R10: `last_cause` records the most recent cause with this priority: power-on=1, then brown-out=2, then short-path bit i = 3+i. When several `fast_evt` bits are set, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| ref_tick | input | 1 | One-cycle reference time tick |
| osc_edge | input | 1 | One-cycle strobe per oscillator period |
| por_evt | input | 1 | Power-on cause pulse |
| bor_evt | input | 1 | Brown-out cause pulse |
| fast_evt | input | N_FAST | Short-path cause pulses (bit 0 pin, 1 watchdog, 2 software, 3 illegal opcode, 4 uninitialized register, 5 trap conflict) |
| pwrt_sel | input | 2 | Power-up delay code |
| clk_src | input | 2 | Clock source: bit 0 crystal, bit 1 PLL |
| sys_reset | output | 1 | System reset, 1 = held |
| clk_en | output | 1 | Core clock enable |
| mon_on | output | 1 | Clock-failure monitoring may run |
| last_cause | output | CAUSE_W | Code of the most recent cause |

## Verification
The hardest case to reach is crystal plus PLL with a short reset delay. Here the reset is released while the start-up count is still running, so S_WAITCLK is entered and the lock and monitor timers overlap with different start points. The bench reaches it by issuing reference ticks alone until release, then oscillator strobes alone, then ticks again. It checks each output at the tick where it should change and at the tick before. The opposite order, where the clock is ready before release, is produced by sending all oscillator strobes before any tick.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_WAITCLK,
        S_RUN
    } rel_state_t;

    typedef enum logic [1:0] {
        C_READY,
        C_OST,
        C_LOCK
    } clk_state_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_POR,
        K_BOR,
        K_FAST
    } cause_kind_t;

endpackage

// File: rtl/rrs_cause_decode.sv
module rrs_cause_decode
    import rrs_pkg::*;
#(
    parameter int N_FAST  = 6,
    parameter int CAUSE_W = 4
) (
    input  logic               por_evt,
    input  logic               bor_evt,
    input  logic [N_FAST-1:0]  fast_evt,
    output logic               any_evt,
    output cause_kind_t        kind,
    output logic [CAUSE_W-1:0] code
);

    always_comb begin
        kind = K_NONE;
        code = '0;
        if (por_evt) begin
            kind = K_POR;
            code = CAUSE_W'(1);
        end else if (bor_evt) begin
            kind = K_BOR;
            code = CAUSE_W'(2);
        end else begin
            for (int i = N_FAST - 1; i >= 0; i--) begin
                if (fast_evt[i]) begin
                    kind = K_FAST;
                    code = CAUSE_W'(3 + i);
                end
            end
        end
    end

    assign any_evt = (kind != K_NONE);

endmodule

// File: rtl/rrs_delay_timer.sv
module rrs_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/rrs_clk_chain.sv
module rrs_clk_chain
    import rrs_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OST_EDGES  = 1024,
    parameter int LOCK_TICKS = 20
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       start,
    input  logic       slow,
    input  logic [1:0] src,
    input  logic       ref_tick,
    input  logic       osc_edge,
    output logic       ready
);

    localparam int OST_W = $clog2(OST_EDGES + 1);

    clk_state_t state_q, state_d;
    logic       pll_q;
    logic       ost_done, lock_done, lock_load;

    always_comb begin
        state_d = state_q;
        if (start) begin
            if (!slow)       state_d = C_READY;
            else if (src[0]) state_d = C_OST;
            else if (src[1]) state_d = C_LOCK;
            else             state_d = C_READY;
        end else begin
            unique case (state_q)
                C_OST:   if (ost_done)  state_d = pll_q ? C_LOCK : C_READY;
                C_LOCK:  if (lock_done) state_d = C_READY;
                C_READY: state_d = C_READY;
                default: state_d = C_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= C_READY;
            pll_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) pll_q <= src[1];
        end
    end

    assign lock_load = start || (state_q == C_OST && state_d == C_LOCK);
    assign ready     = (state_q == C_READY);

    rrs_delay_timer #(.W(OST_W)) u_ost (
        .clk      (clk),
        .arst_n   (arst_n),
        .load     (start),
        .load_val (OST_W'(OST_EDGES)),
        .step     (osc_edge),
        .done     (ost_done)
    );

    rrs_delay_timer #(.W(CNT_W)) u_lock (
        .clk      (clk),
        .arst_n   (arst_n),
        .load     (lock_load),
        .load_val (CNT_W'(LOCK_TICKS)),
        .step     (ref_tick),
        .done     (lock_done)
    );

endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
    import rrs_pkg::*;
#(
    parameter int N_FAST       = 6,
    parameter int CNT_W        = 24,
    parameter int TICKS_PER_MS = 1000,
    parameter int POR_TICKS    = 10,
    parameter int LOCK_TICKS   = 20,
    parameter int MON_TICKS    = 100,
    parameter int OST_EDGES    = 1024,
    localparam int CAUSE_W     = $clog2(N_FAST + 3)
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               ref_tick,
    input  logic               osc_edge,
    input  logic               por_evt,
    input  logic               bor_evt,
    input  logic [N_FAST-1:0]  fast_evt,
    input  logic [1:0]         pwrt_sel,
    input  logic [1:0]         clk_src,
    output logic               sys_reset,
    output logic               clk_en,
    output logic               mon_on,
    output logic [CAUSE_W-1:0] last_cause
);

    rel_state_t          state_q, state_d;
    cause_kind_t         kind;
    logic                any_evt;
    logic [CAUSE_W-1:0]  code;
    logic [CNT_W-1:0]    pw_ticks, rst_load;
    logic                rst_done, clk_ready, mon_done, release_go;
    logic                mon_armed, fast_q;
    logic [1:0]          src_q;

    rrs_cause_decode #(.N_FAST(N_FAST), .CAUSE_W(CAUSE_W)) u_dec (
        .por_evt  (por_evt),
        .bor_evt  (bor_evt),
        .fast_evt (fast_evt),
        .any_evt  (any_evt),
        .kind     (kind),
        .code     (code)
    );

    always_comb begin
        unique case (pwrt_sel)
            2'd0: pw_ticks = '0;
            2'd1: pw_ticks = CNT_W'(4 * TICKS_PER_MS);
            2'd2: pw_ticks = CNT_W'(16 * TICKS_PER_MS);
            2'd3: pw_ticks = CNT_W'(64 * TICKS_PER_MS);
            default: pw_ticks = '0;
        endcase
        unique case (kind)
            K_POR:   rst_load = CNT_W'(POR_TICKS) + pw_ticks;
            K_BOR:   rst_load = pw_ticks;
            default: rst_load = '0;
        endcase
    end

    rrs_delay_timer #(.W(CNT_W)) u_rst_tmr (
        .clk      (clk),
        .arst_n   (arst_n),
        .load     (any_evt),
        .load_val (rst_load),
        .step     (ref_tick),
        .done     (rst_done)
    );

    rrs_clk_chain #(
        .CNT_W      (CNT_W),
        .OST_EDGES  (OST_EDGES),
        .LOCK_TICKS (LOCK_TICKS)
    ) u_clk (
        .clk      (clk),
        .arst_n   (arst_n),
        .start    (any_evt),
        .slow     (kind == K_POR || kind == K_BOR),
        .src      (clk_src),
        .ref_tick (ref_tick),
        .osc_edge (osc_edge),
        .ready    (clk_ready)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (any_evt) begin
            state_d = S_HOLD;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_HOLD:    if (rst_done) state_d = clk_ready ? S_RUN : S_WAITCLK;
                S_WAITCLK: if (clk_ready) state_d = S_RUN;
                S_RUN:     state_d = S_RUN;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // state register and cause/monitor bookkeeping
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q    <= S_IDLE;
            last_cause <= '0;
            src_q      <= 2'b00;
            fast_q     <= 1'b0;
            mon_armed  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (any_evt) begin
                last_cause <= code;
                src_q      <= clk_src;
                fast_q     <= (kind == K_FAST);
                mon_armed  <= 1'b0;
            end else if (release_go) begin
                mon_armed  <= 1'b1;
            end
        end
    end

    assign release_go = (state_q == S_HOLD) && rst_done && !any_evt;

    rrs_delay_timer #(.W(CNT_W)) u_mon_tmr (
        .clk      (clk),
        .arst_n   (arst_n),
        .load     (release_go),
        .load_val (fast_q ? '0 : CNT_W'(MON_TICKS)),
        .step     (ref_tick),
        .done     (mon_done)
    );

    // outputs
    always_comb begin
        sys_reset = (state_q == S_IDLE) || (state_q == S_HOLD);
        clk_en    = (state_q == S_RUN);
        mon_on    = mon_armed && mon_done && (src_q != 2'b00);
    end

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int N_FAST  = 6,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               arst_n,
    input logic               por_evt,
    input logic               bor_evt,
    input logic [N_FAST-1:0]  fast_evt,
    input logic               sys_reset,
    input logic               clk_en,
    input logic               mon_on,
    input logic [CAUSE_W-1:0] last_cause,
    input logic [1:0]         src_q
);

    logic any_c, fast_only;
    assign any_c     = por_evt || bor_evt || (|fast_evt);
    assign fast_only = (|fast_evt) && !por_evt && !bor_evt;

    AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
        clk_en |-> !sys_reset);                                      // R7

    AST_MON_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
        mon_on |-> !sys_reset);                                      // R8

    AST_MON_NOT_PLAIN: assert property (@(posedge clk) disable iff (!arst_n)
        mon_on |-> (src_q != 2'b00));                                // R8

    AST_EVENT_RESTARTS: assert property (@(posedge clk) disable iff (!arst_n)
        any_c |=> (sys_reset && !clk_en && !mon_on));                // R9

    AST_POR_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
        por_evt |=> (last_cause == CAUSE_W'(1)));                    // R10

    AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
        (fast_only ##1 !any_c) |=> (!sys_reset && clk_en));          // R4

endmodule

bind reset_release_seq rrs_checker #(.N_FAST(N_FAST), .CAUSE_W(CAUSE_W)) u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .por_evt    (por_evt),
    .bor_evt    (bor_evt),
    .fast_evt   (fast_evt),
    .sys_reset  (sys_reset),
    .clk_en     (clk_en),
    .mon_on     (mon_on),
    .last_cause (last_cause),
    .src_q      (src_q)
);

// File: tb/tb_reset_release_seq.sv
module tb_reset_release_seq;

    localparam int NF = 6;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          arst_n = 1'b0;
    logic          ref_tick = 1'b0, osc_edge = 1'b0;
    logic          por_evt = 1'b0, bor_evt = 1'b0;
    logic [NF-1:0] fast_evt = '0;
    logic [1:0]    pwrt_sel = 2'd0, clk_src = 2'd0;
    logic          sys_reset, clk_en, mon_on;
    logic [CW-1:0] last_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    reset_release_seq #(
        .N_FAST(NF), .CNT_W(16), .TICKS_PER_MS(2), .POR_TICKS(3),
        .LOCK_TICKS(5), .MON_TICKS(7), .OST_EDGES(16)
    ) dut (
        .clk(clk), .arst_n(arst_n), .ref_tick(ref_tick), .osc_edge(osc_edge),
        .por_evt(por_evt), .bor_evt(bor_evt), .fast_evt(fast_evt),
        .pwrt_sel(pwrt_sel), .clk_src(clk_src), .sys_reset(sys_reset),
        .clk_en(clk_en), .mon_on(mon_on), .last_cause(last_cause)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic outs(input string req, input int r, input int c, input int m);
        check(req, "sys_reset", int'(sys_reset), r);
        check(req, "clk_en", int'(clk_en), c);
        check(req, "mon_on", int'(mon_on), m);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic oscs(input int n);
        for (int i = 0; i < n; i++) begin
            osc_edge = 1'b1;
            @(negedge clk);
            osc_edge = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // one-cycle cause pulse; returns at the negedge after the capturing edge
    task automatic fire(input logic p, input logic b, input logic [NF-1:0] f,
                        input logic [1:0] src, input logic [1:0] pw);
        por_evt = p; bor_evt = b; fast_evt = f; clk_src = src; pwrt_sel = pw;
        @(negedge clk);
        por_evt = 1'b0; bor_evt = 1'b0; fast_evt = '0;
    endtask

    task automatic t_reset_state;
        outs("R1", 1, 0, 0);
        check("R1", "last_cause", int'(last_cause), 0);
        ticks(3); oscs(2);
        outs("R1", 1, 0, 0);
    endtask

    task automatic t_por_plain;
        fire(1, 0, '0, 2'd0, 2'd1);           // 3 + 4*2 = 11 ticks
        check("R10", "last_cause", int'(last_cause), 1);
        ticks(10);
        outs("R2", 1, 0, 0);
        ticks(1);
        outs("R2", 0, 1, 0);
        ticks(8);
        check("R8", "mon_on plain", int'(mon_on), 0);
    endtask

    task automatic t_bor_zero;
        fire(0, 1, '0, 2'd0, 2'd0);
        check("R3", "sys_reset held", int'(sys_reset), 1);
        check("R10", "last_cause", int'(last_cause), 2);
        @(negedge clk);
        outs("R3", 0, 1, 0);
    endtask

    task automatic t_bor_crystal;
        fire(0, 1, '0, 2'd1, 2'd2);           // 16*2 = 32 ticks
        oscs(16);
        outs("R7", 1, 0, 0);
        ticks(31);
        outs("R3", 1, 0, 0);
        ticks(1);
        outs("R7", 0, 1, 0);
        ticks(6);
        check("R8", "mon_on early", int'(mon_on), 0);
        ticks(1);
        check("R8", "mon_on", int'(mon_on), 1);
    endtask

    task automatic t_por_xtal_pll;
        fire(1, 0, '0, 2'd3, 2'd0);           // 3 ticks reset
        ticks(3);
        outs("R7", 0, 0, 0);
        oscs(15);
        check("R5", "clk_en before count", int'(clk_en), 0);
        oscs(1);
        ticks(4);
        check("R6", "clk_en during lock", int'(clk_en), 0);
        ticks(1);
        check("R6", "clk_en after lock", int'(clk_en), 1);
        check("R8", "mon_on early", int'(mon_on), 0);
        ticks(2);
        check("R8", "mon_on", int'(mon_on), 1);
    endtask

    task automatic t_por_pll_only;
        fire(1, 0, '0, 2'd2, 2'd0);
        ticks(3);
        outs("R7", 0, 0, 0);
        ticks(2);
        outs("R6", 0, 1, 0);
        oscs(20);
        check("R5", "no osc effect", int'(clk_en), 1);
    endtask

    task automatic t_restart;
        fire(1, 0, '0, 2'd0, 2'd1);
        ticks(6);
        fire(1, 0, '0, 2'd0, 2'd1);
        outs("R9", 1, 0, 0);
        ticks(10);
        check("R9", "held after restart", int'(sys_reset), 1);
        ticks(1);
        check("R9", "released", int'(sys_reset), 0);
    endtask

    task automatic t_fast;
        fire(0, 1, '0, 2'd1, 2'd0);
        oscs(16); ticks(7);
        outs("R8", 0, 1, 1);
        fire(0, 0, 6'b000010, 2'd1, 2'd3);
        outs("R4", 1, 0, 0);
        check("R10", "watchdog code", int'(last_cause), 4);
        @(negedge clk);
        outs("R4", 0, 1, 1);
    endtask

    task automatic t_priority;
        fire(1, 0, 6'b000001, 2'd0, 2'd0);
        check("R10", "por over fast", int'(last_cause), 1);
        fire(0, 1, 6'b100000, 2'd0, 2'd0);
        check("R10", "bor over fast", int'(last_cause), 2);
        fire(0, 0, 6'b101000, 2'd0, 2'd0);
        check("R10", "lowest fast bit", int'(last_cause), 6);
        fire(0, 0, 6'b100000, 2'd0, 2'd0);
        check("R10", "trap conflict", int'(last_cause), 8);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_por_plain();
        t_bor_zero();
        t_bor_crystal();
        t_por_xtal_pll();
        t_por_pll_only();
        t_restart();
        t_fast();
        t_priority();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

endmodule